// File: doc/BRIEF.md
# Six-Bit Accumulator Execute Unit

This block is the arithmetic and logic stage of a small 6-bit accumulator processor. It holds the working register A, the result register B and the zero (Z) and carry (C) flags. Each cycle in which the execute strobe is high, it decodes a 6-bit opcode and combines A with a 6-bit operand word supplied by the surrounding core. It then updates the registers. Operand fetch, memory, the program counter and branching belong to the surrounding core.

The two-operand operations are add, add with carry, subtract, subtract with borrow, equality test, unsigned greater-than test, XOR and AND. Each can either copy its result back into A or leave A alone. Four single-word opcodes act on A or on C alone: two right shifts, set carry and clear carry. All four registers are visible as outputs, so the core can read A, B and the flags directly.

Top module: `alu6_exec`

## Requirements
- R1: While rst_n is low, and after it is released until the first strobe, a_q, b_q, z_q and c_q are all zero.
- R2: With exec_en low, no register changes whatever the opcode and operand.
- R3: Opcode field op[3:0]=4 (add) loads B with (A+operand) mod 64 and C with the carry out of bit 5. Field 5 (add with carry) also adds the current C.
- R4: Field 6 (subtract) computes A + ~operand + 1. Field 7 (subtract with borrow) computes A + ~operand + C. Both load B with the low 6 bits and C with the carry out of bit 5, so C=1 means no borrow.
- R5: For fields 4 to 11, op[4]=0 also loads the result into A. op[4]=1 leaves A unchanged.
- R6: After any of the fields 4 to 11, or a shift, Z is 1 exactly when the 6-bit result is zero.
- R7: Field 8 writes 1 to B when A equals the operand and 0 otherwise. Field 9 writes 1 when A is greater than the operand as unsigned numbers and 0 otherwise. Both leave C unchanged.
- R8: Field 10 writes A XOR operand and field 11 writes A AND operand. Both leave C unchanged.
- R9: Full opcode 18 writes {0, A[5:1]} to B. Full opcode 19 writes {C, A[5:1]} to B. Both load C with the old A[0] and never change A.
- R10: Full opcode 17 sets C to 1 and full opcode 32 clears C to 0. A, B and Z are unchanged.
- R11: Any other opcode (for example 0, 1, 12, 15, 49, 50, 63) changes no register even with exec_en high.
- R12: For fields 4 to 11, op[5] has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | One-cycle execute strobe |
| op | input | 6 | Opcode |
| opnd | input | 6 | Operand word |
| a_q | output | 6 | A register |
| b_q | output | 6 | B register |
| z_q | output | 1 | Zero flag |
| c_q | output | 1 | Carry flag |

## Verification
The hardest states to reach from the ports are those that need A to hold a chosen value together with a chosen carry. The only way to write A is through an operation that writes its result back. The bench therefore loads A with an XOR that writes back, using an operand equal to the tracked A XOR the target. It then sets or clears C with the carry opcodes. From that state it drives subtract and add to the borrow and wrap boundaries (0-1, x-x, 63+1). It also drives each compare with equal, greater and smaller operands while C is deliberately set, so that any change to C is seen.

// File: rtl/alu6_exec.sv
module alu6_exec #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_en,
  input  logic [5:0]   op,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         z_q,
  output logic         c_q
);
  localparam logic [5:0] OP_SEC  = 6'd17;
  localparam logic [5:0] OP_RSH  = 6'd18;
  localparam logic [5:0] OP_RSHC = 6'd19;
  localparam logic [5:0] OP_CLC  = 6'd32;

  logic [3:0]   fn;
  logic         is_alu, quick, is_sub, is_arith, is_rsh, cin;
  logic [W-1:0] addend, res, sh_res;
  logic [W:0]   sum;

  assign fn       = op[3:0];
  assign is_alu   = (fn >= 4'd4) && (fn <= 4'd11);
  assign is_arith = (fn >= 4'd4) && (fn <= 4'd7);
  assign quick    = op[4];
  assign is_sub   = (fn == 4'd6) || (fn == 4'd7);
  assign is_rsh   = (op == OP_RSH) || (op == OP_RSHC);
  assign addend   = is_sub ? ~opnd : opnd;
  assign cin      = (fn == 4'd5 || fn == 4'd7) ? c_q : is_sub;
  assign sum      = {1'b0, a_q} + {1'b0, addend} + {{W{1'b0}}, cin};
  assign sh_res   = {(op[0] & c_q), a_q[W-1:1]};

  always_comb begin
    case (fn)
      4'd8:    res = {{(W-1){1'b0}}, a_q == opnd};
      4'd9:    res = {{(W-1){1'b0}}, a_q > opnd};
      4'd10:   res = a_q ^ opnd;
      4'd11:   res = a_q & opnd;
      default: res = sum[W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (exec_en) begin
      if (is_alu) begin
        b_q <= res;
        z_q <= (res == '0);
        if (!quick)   a_q <= res;
        if (is_arith) c_q <= sum[W];
      end else if (is_rsh) begin
        b_q <= sh_res;
        z_q <= (sh_res == '0);
        c_q <= a_q[0];
      end else if (op == OP_SEC) begin
        c_q <= 1'b1;
      end else if (op == OP_CLC) begin
        c_q <= 1'b0;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(a_q) && $stable(b_q) && $stable(z_q) && $stable(c_q));

  p_quick_keeps_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_alu && quick |=> $stable(a_q));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (is_alu || is_rsh) |=> z_q == (b_q == '0));

  p_compare_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (fn == 4'd8 || fn == 4'd9) |=> b_q[W-1:1] == '0 && $stable(c_q));

  p_shift_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_rsh |=> c_q == $past(a_q[0]) && $stable(a_q));

  p_carry_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == OP_SEC || op == OP_CLC) |=> c_q == !$past(op[5]) && $stable(b_q) && $stable(a_q));
endmodule

// File: tb/sim_alu6_exec.sv
module sim_alu6_exec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [5:0] op = '0;
  logic [5:0] opnd = '0;
  logic [5:0] a_q, b_q;
  logic       z_q, c_q;

  int checks = 0;
  int errors = 0;
  logic [5:0] m_a = '0, m_b = '0;
  logic       m_z = 1'b0, m_c = 1'b0;

  always #2 clk = ~clk;

  alu6_exec u0 (.clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .opnd(opnd),
                .a_q(a_q), .b_q(b_q), .z_q(z_q), .c_q(c_q));

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model(input logic [5:0] o, input logic [5:0] d, input logic en);
    logic [6:0] s;
    logic [5:0] r;
    int f;
    f = o[3:0];
    if (!en) return;
    if (f >= 4 && f <= 11) begin
      case (f)
        4: s = m_a + d;
        5: s = m_a + d + m_c;
        6: s = m_a + (7'd63 - d) + 1;
        7: s = m_a + (7'd63 - d) + m_c;
        default: s = '0;
      endcase
      case (f)
        8:  r = (m_a == d) ? 6'd1 : 6'd0;
        9:  r = (m_a > d) ? 6'd1 : 6'd0;
        10: r = m_a ^ d;
        11: r = m_a & d;
        default: r = s[5:0];
      endcase
      if (f <= 7) m_c = s[6];
      m_b = r;
      m_z = (r == 0);
      if (!o[4]) m_a = r;
    end else if (o == 18 || o == 19) begin
      r = {(o == 19) ? m_c : 1'b0, m_a[5:1]};
      m_c = m_a[0];
      m_b = r;
      m_z = (r == 0);
    end else if (o == 17) m_c = 1'b1;
    else if (o == 32) m_c = 1'b0;
  endtask

  task automatic step(input string tag, input logic [5:0] o, input logic [5:0] d, input logic en = 1'b1);
    @(negedge clk);
    op = o; opnd = d; exec_en = en;
    model(o, d, en);
    @(negedge clk);
    exec_en = 1'b0;
    check(tag, "A", a_q, m_a);
    check(tag, "B", b_q, m_b);
    check(tag, "Z", z_q, m_z);
    check(tag, "C", c_q, m_c);
  endtask

  task automatic load_a(input logic [5:0] v);
    step("R5", 6'd10, m_a ^ v);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1", "A", a_q, 0); check("R1", "B", b_q, 0);
    check("R1", "Z", z_q, 0); check("R1", "C", c_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "A after release", a_q, 0);
  endtask

  task automatic t_hold;
    load_a(6'd21);
    step("R2", 6'd4, 6'd7, 1'b0);
    step("R2", 6'd17, 6'd0, 1'b0);
    step("R2", 6'd18, 6'd0, 1'b0);
  endtask

  task automatic t_add;
    load_a(6'd63); step("R3", 6'd4, 6'd1);
    check("R3", "wrap C", c_q, 1); check("R6", "wrap Z", z_q, 1);
    load_a(6'd10); step("R3", 6'd17, 6'd0); step("R3", 6'd5, 6'd20);
    check("R3", "adc B", b_q, 31);
  endtask

  task automatic t_sub;
    load_a(6'd0); step("R4", 6'd6, 6'd1);
    check("R4", "borrow B", b_q, 63); check("R4", "borrow C", c_q, 0);
    load_a(6'd5); step("R4", 6'd6, 6'd5);
    check("R4", "equal C", c_q, 1); check("R6", "equal Z", z_q, 1);
    load_a(6'd9); step("R4", 6'd32, 6'd0); step("R4", 6'd7, 6'd3);
    check("R4", "sbc B", b_q, 5);
    step("R4", 6'd17, 6'd0); step("R4", 6'd23, 6'd3);
  endtask

  task automatic t_compare;
    load_a(6'd30); step("R7", 6'd17, 6'd0);
    step("R7", 6'd24, 6'd30); check("R7", "eq B", b_q, 1);
    step("R7", 6'd24, 6'd31); check("R7", "neq Z", z_q, 1);
    step("R7", 6'd25, 6'd29); check("R7", "gt B", b_q, 1);
    step("R7", 6'd25, 6'd30); check("R7", "not gt B", b_q, 0);
    step("R7", 6'd32, 6'd0); step("R7", 6'd9, 6'd63);
    check("R7", "C kept", c_q, 0);
  endtask

  task automatic t_logic;
    load_a(6'd42); step("R8", 6'd17, 6'd0);
    step("R8", 6'd26, 6'd42); check("R8", "xor zero", b_q, 0);
    step("R8", 6'd11, 6'd15); check("R8", "and A", a_q, 10);
    check("R8", "C kept", c_q, 1);
  endtask

  task automatic t_shift;
    load_a(6'd33); step("R9", 6'd17, 6'd0);
    step("R9", 6'd18, 6'd0); check("R9", "rsh B", b_q, 16);
    step("R9", 6'd19, 6'd0); check("R9", "rshc B", b_q, 48);
    load_a(6'd1); step("R9", 6'd18, 6'd0);
    check("R9", "rsh Z", z_q, 1); check("R9", "A kept", a_q, 1);
  endtask

  task automatic t_carry;
    step("R10", 6'd17, 6'd5); step("R10", 6'd32, 6'd5); step("R10", 6'd17, 6'd0);
  endtask

  task automatic t_unused;
    load_a(6'd12);
    step("R11", 6'd0, 6'd3); step("R11", 6'd1, 6'd3); step("R11", 6'd12, 6'd3);
    step("R11", 6'd15, 6'd3); step("R11", 6'd49, 6'd3); step("R11", 6'd50, 6'd3);
    step("R11", 6'd63, 6'd3);
  endtask

  task automatic t_ibit;
    load_a(6'd50); step("R12", 6'd36, 6'd20); check("R12", "I add A", a_q, 6);
    step("R12", 6'd58, 6'd5); step("R12", 6'd59, 6'd7);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [5:0] o, d;
      o = {$urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 4'($urandom_range(11, 4))};
      d = 6'($urandom);
      if (i % 7 == 0) step("R10", ($urandom_range(1, 0) == 1) ? 6'd17 : 6'd32, d);
      if (i % 5 == 0) step("R9", ($urandom_range(1, 0) == 1) ? 6'd18 : 6'd19, d);
      step("R5", o, d);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_hold;
    t_add;
    t_sub;
    t_compare;
    t_logic;
    t_shift;
    t_carry;
    t_unused;
    t_ibit;
    t_random;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule